// File: doc/BRIEF.md
# Privilege Stack Trap Controller

This block keeps a compact machine status word. The word holds the current privilege level and interrupt enable, plus two saved levels that form a three-deep history. Each cycle the block looks at four pending-interrupt sources, a synchronous trap request, a trap-return strobe and a status write. It then acts on at most one of them, in a fixed priority order. A trap or a taken interrupt pushes the history and enters machine mode. It also records the faulting PC and a cause code, and issues a one-cycle redirect to a vector. That vector depends on the privilege level that was active before the push.

A trap return pops the history and redirects to the saved exception PC. A status write accepts the enable bits as written. It rejects any privilege field that holds the reserved encoding, and that field keeps its old value. A core uses the block as follows: it feeds the PC of the instruction being retired and follows `redirValid`/`redirPc` on the next cycle.

Top module: `trap_stack_ctrl`

## Requirements
- R1: After reset the status word reads 0x04B (current privilege machine, both saved privileges supervisor, all enables 0, memory privilege user). In addition, `redirPc` is 0x100, `redirValid` is 0, and the exception PC and cause are 0.
- R2: On trap entry, saved level 2 receives saved level 1 (privilege and enable), and saved level 1 receives the current privilege and enable. The current privilege then becomes machine (3), the current enable becomes 0, and the memory-privilege field becomes machine.
- R3: On trap return, the current level receives saved level 1, and saved level 1 receives saved level 2. Saved level 2 is refilled with user privilege and enable 1. On the next cycle `redirValid` is 1 and `redirPc` equals the stored exception PC.
- R4: On trap entry, on the next cycle `redirValid` is 1 and `redirPc` is 64 times the privilege level in force before the push. Also, `epcOut` holds the `pcIn` of the entry cycle and `causeOut` holds the cause.
- R5: A machine-level interrupt (`msip`, or `hostPending`) is taken when the current privilege is below machine, or when it is machine with the current enable at 1.
- R6: A supervisor-level interrupt (`ssip`, or `timerPending` gated by status bit 11) is taken when the privilege is user, or when it is supervisor with the current enable at 1.
- R7: On a status write, each 2-bit privilege field is updated only when the written value is 0, 1 or 3. A written 2 leaves that field at its old value. Enable bits and bit 11 take the written value.
- R8: An interrupt cause has bit 31 set, and the interrupt number sits in the low bits: software is 0, timer is 1, host message is 2. A synchronous trap stores `trapCause` unchanged.
- R9: Priority runs from highest to lowest: machine software, host message, supervisor software, supervisor timer, synchronous trap, trap return, status write. The lower events of the same cycle are dropped.
- R10: The status word layout is as follows. Bits [1:0] hold the current privilege and bit 2 the current enable. Bits [4:3] and bit 5 hold saved level 1, and bits [7:6] and bit 8 hold saved level 2. Bits [10:9] hold the memory privilege and bit 11 the supervisor timer enable. The privilege encoding is user 0, supervisor 1, machine 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pcIn | input | 32 | PC of the instruction being retired |
| trapReq | input | 1 | Synchronous trap request |
| trapCause | input | 32 | Cause code for a synchronous trap |
| retReq | input | 1 | Trap-return strobe |
| msip | input | 1 | Machine software interrupt pending |
| ssip | input | 1 | Supervisor software interrupt pending |
| hostPending | input | 1 | Host message register is nonzero |
| timerPending | input | 1 | Supervisor timer compare reached |
| csrWe | input | 1 | Status word write strobe |
| csrWdata | input | 12 | Status word write value |
| statusOut | output | 12 | Current status word |
| privOut | output | 2 | Current privilege level |
| redirValid | output | 1 | Redirect request, one cycle |
| redirPc | output | 32 | Redirect target |
| epcOut | output | 32 | Saved exception PC |
| causeOut | output | 32 | Saved cause |

## Verification
The assertions assume that the reserved privilege encoding can enter only through the status write port, where it is filtered. They also assume that the interrupt sources are plain levels that need no acknowledgement. The stimulus sweeps every 12-bit value through the write port, including every field combination that holds the reserved code. It then sweeps every privilege, enable, timer-enable and source combination. Before each combination it sets the status through a write cycle with all sources low, so every interrupt decision starts from a known word. The bench model tracks the stack independently, and fault, return and write strobes are raised together to exercise the ordering.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int ST_W  = 12;
  localparam int IRQ_W = 4;

  localparam logic [1:0] PRIV_U   = 2'd0;
  localparam logic [1:0] PRIV_S   = 2'd1;
  localparam logic [1:0] PRIV_BAD = 2'd2;
  localparam logic [1:0] PRIV_M   = 2'd3;

  localparam logic [IRQ_W-1:0] IRQ_SOFT  = IRQ_W'(0);
  localparam logic [IRQ_W-1:0] IRQ_TIMER = IRQ_W'(1);
  localparam logic [IRQ_W-1:0] IRQ_HOST  = IRQ_W'(2);

  typedef struct packed {
    logic             doEntry;
    logic             doReturn;
    logic             doWrite;
    logic             isIrq;
    logic [IRQ_W-1:0] irqNum;
  } tsc_strobe_t;

  function automatic logic privOk(input logic [1:0] p);
    return p != PRIV_BAD;
  endfunction
endpackage

// File: rtl/tsc_ctrl.sv
module tsc_ctrl
  import tsc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  curPriv,
  input  logic        curIe,
  input  logic        timerEn,
  input  logic        msip,
  input  logic        ssip,
  input  logic        hostPending,
  input  logic        timerPending,
  input  logic        trapReq,
  input  logic        retReq,
  input  logic        csrWe,
  output tsc_strobe_t strobe
);
  logic mOpen, sOpen, irqHit;
  logic [IRQ_W-1:0] irqNum;

  always_comb begin
    mOpen  = (curPriv != PRIV_M) || curIe;
    sOpen  = (curPriv == PRIV_U) || ((curPriv == PRIV_S) && curIe);
    irqHit = 1'b1;
    irqNum = IRQ_SOFT;
    if (mOpen && msip)                          irqNum = IRQ_SOFT;
    else if (mOpen && hostPending)              irqNum = IRQ_HOST;
    else if (sOpen && ssip)                     irqNum = IRQ_SOFT;
    else if (sOpen && timerPending && timerEn)  irqNum = IRQ_TIMER;
    else                                        irqHit = 1'b0;
  end

  always_comb begin
    strobe.isIrq    = irqHit;
    strobe.irqNum   = irqNum;
    strobe.doEntry  = irqHit || trapReq;
    strobe.doReturn = !strobe.doEntry && retReq;
    strobe.doWrite  = !strobe.doEntry && !retReq && csrWe;
  end

  // R5: machine mode with enable clear never takes an interrupt
  a_r5_masked_at_m: assert property (@(posedge clk) disable iff (!rstN)
    (curPriv == PRIV_M && !curIe && !trapReq) |-> !strobe.doEntry);
  // R9: a fault beats return and write
  a_r9_fault_first: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> (strobe.doEntry && !strobe.doReturn && !strobe.doWrite));
  // R8: an interrupt entry needs a live source
  a_r8_irq_source: assert property (@(posedge clk) disable iff (!rstN)
    strobe.isIrq |-> (msip || ssip || hostPending || timerPending));
endmodule

// File: rtl/tsc_datapath.sv
module tsc_datapath
  import tsc_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter logic [31:0] RESET_PC   = 32'h100,
  parameter int          VEC_STRIDE = 64
)(
  input  logic             clk,
  input  logic             rstN,
  input  tsc_strobe_t      strobe,
  input  logic [XLEN-1:0]  pcIn,
  input  logic [XLEN-1:0]  trapCause,
  input  logic [ST_W-1:0]  csrWdata,
  output logic [ST_W-1:0]  status,
  output logic             redirValid,
  output logic [XLEN-1:0]  redirPc,
  output logic [XLEN-1:0]  epc,
  output logic [XLEN-1:0]  cause
);
  localparam logic [XLEN-1:0] STRIDE = XLEN'(VEC_STRIDE);

  logic [1:0] privC, priv1, priv2, mprv;
  logic ieC, ie1, ie2, timerEn;
  logic [XLEN-1:0] irqCause;

  always_comb begin
    irqCause = '0;
    irqCause[XLEN-1] = 1'b1;
    irqCause[IRQ_W-1:0] = strobe.irqNum;
    status = {timerEn, mprv, ie2, priv2, ie1, priv1, ieC, privC};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      privC <= PRIV_M;  ieC <= 1'b0;
      priv1 <= PRIV_S;  ie1 <= 1'b0;
      priv2 <= PRIV_S;  ie2 <= 1'b0;
      mprv  <= PRIV_U;  timerEn <= 1'b0;
      epc <= '0;  cause <= '0;
      redirPc <= XLEN'(RESET_PC);
      redirValid <= 1'b0;
    end else begin
      redirValid <= 1'b0;
      if (strobe.doEntry) begin
        priv2 <= priv1;  ie2 <= ie1;
        priv1 <= privC;  ie1 <= ieC;
        privC <= PRIV_M; ieC <= 1'b0;
        mprv  <= PRIV_M;
        epc   <= pcIn;
        cause <= strobe.isIrq ? irqCause : trapCause;
        redirPc <= STRIDE * XLEN'(privC);
        redirValid <= 1'b1;
      end else if (strobe.doReturn) begin
        privC <= priv1;  ieC <= ie1;
        priv1 <= priv2;  ie1 <= ie2;
        priv2 <= PRIV_U; ie2 <= 1'b1;
        redirPc <= epc;
        redirValid <= 1'b1;
      end else if (strobe.doWrite) begin
        if (privOk(csrWdata[1:0]))  privC <= csrWdata[1:0];
        if (privOk(csrWdata[4:3]))  priv1 <= csrWdata[4:3];
        if (privOk(csrWdata[7:6]))  priv2 <= csrWdata[7:6];
        if (privOk(csrWdata[10:9])) mprv  <= csrWdata[10:9];
        ieC <= csrWdata[2];
        ie1 <= csrWdata[5];
        ie2 <= csrWdata[8];
        timerEn <= csrWdata[11];
      end
    end
  end

  a_r2_push: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doEntry |=> (privC == PRIV_M && !ieC && mprv == PRIV_M &&
      priv1 == $past(privC) && ie1 == $past(ieC) &&
      priv2 == $past(priv1) && ie2 == $past(ie1)));
  a_r3_pop: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doReturn |=> (privC == $past(priv1) && ieC == $past(ie1) &&
      priv1 == $past(priv2) && ie1 == $past(ie2) &&
      priv2 == PRIV_U && ie2 && redirValid && redirPc == $past(epc)));
  a_r4_vector: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doEntry |=> (redirValid && redirPc == STRIDE * XLEN'($past(privC)) &&
      epc == $past(pcIn)));
  a_r7_no_reserved: assert property (@(posedge clk) disable iff (!rstN)
    (privC != PRIV_BAD && priv1 != PRIV_BAD && priv2 != PRIV_BAD && mprv != PRIV_BAD));
endmodule

// File: rtl/trap_stack_ctrl.sv
module trap_stack_ctrl
  import tsc_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter logic [31:0] RESET_PC   = 32'h100,
  parameter int          VEC_STRIDE = 64
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [XLEN-1:0]   pcIn,
  input  logic              trapReq,
  input  logic [XLEN-1:0]   trapCause,
  input  logic              retReq,
  input  logic              msip,
  input  logic              ssip,
  input  logic              hostPending,
  input  logic              timerPending,
  input  logic              csrWe,
  input  logic [ST_W-1:0]   csrWdata,
  output logic [ST_W-1:0]   statusOut,
  output logic [1:0]        privOut,
  output logic              redirValid,
  output logic [XLEN-1:0]   redirPc,
  output logic [XLEN-1:0]   epcOut,
  output logic [XLEN-1:0]   causeOut
);
  tsc_strobe_t strobe;
  logic [ST_W-1:0] status;

  tsc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .curPriv(status[1:0]), .curIe(status[2]), .timerEn(status[11]),
    .msip(msip), .ssip(ssip), .hostPending(hostPending), .timerPending(timerPending),
    .trapReq(trapReq), .retReq(retReq), .csrWe(csrWe),
    .strobe(strobe)
  );

  tsc_datapath #(.XLEN(XLEN), .RESET_PC(RESET_PC), .VEC_STRIDE(VEC_STRIDE)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .pcIn(pcIn), .trapCause(trapCause), .csrWdata(csrWdata),
    .status(status), .redirValid(redirValid), .redirPc(redirPc),
    .epc(epcOut), .cause(causeOut)
  );

  assign statusOut = status;
  assign privOut   = status[1:0];
endmodule

// File: tb/sim_trap_stack_ctrl.sv
`timescale 1ns/1ps
module sim_trap_stack_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] pcIn = '0, trapCause = '0;
  logic trapReq = 0, retReq = 0, msip = 0, ssip = 0, hostPending = 0, timerPending = 0, csrWe = 0;
  logic [11:0] csrWdata = '0;
  logic [11:0] statusOut;
  logic [1:0]  privOut;
  logic        redirValid;
  logic [31:0] redirPc, epcOut, causeOut;

  int vectors = 0;
  int miscompares = 0;

  // bench model
  logic [1:0] mP, p1, p2, mv;
  logic mI, i1, i2, st;
  logic [31:0] eEpc, eCause, eRedir;
  logic eValid;

  trap_stack_ctrl u0 (
    .clk(clk), .rstN(rstN), .pcIn(pcIn), .trapReq(trapReq), .trapCause(trapCause),
    .retReq(retReq), .msip(msip), .ssip(ssip), .hostPending(hostPending),
    .timerPending(timerPending), .csrWe(csrWe), .csrWdata(csrWdata),
    .statusOut(statusOut), .privOut(privOut), .redirValid(redirValid),
    .redirPc(redirPc), .epcOut(epcOut), .causeOut(causeOut)
  );

  always #10 clk = ~clk;

  function automatic logic [11:0] packSt();
    return {st, mv, i2, p2, i1, p1, mI, mP};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkAll(input string req);
    chk({req, " status"}, 32'(statusOut), 32'(packSt()));
    chk({req, " priv"}, 32'(privOut), 32'(mP));
    chk({req, " valid"}, 32'(redirValid), 32'(eValid));
    if (eValid) chk({req, " redir"}, redirPc, eRedir);
    chk({req, " epc"}, epcOut, eEpc);
    chk({req, " cause"}, causeOut, eCause);
  endtask

  task automatic apply(input string req, input logic [31:0] pc, input logic tr,
                       input logic [31:0] tc, input logic rt, input logic ms,
                       input logic ss, input logic ho, input logic tm,
                       input logic we, input logic [11:0] wd);
    logic mOpen, sOpen, hit;
    logic [31:0] ic;
    pcIn = pc; trapReq = tr; trapCause = tc; retReq = rt; msip = ms; ssip = ss;
    hostPending = ho; timerPending = tm; csrWe = we; csrWdata = wd;
    // expected outcome, from R5 R6 R8 R9
    mOpen = (mP != 2'd3) || mI;
    sOpen = (mP == 2'd0) || (mP == 2'd1 && mI);
    hit = 1'b1;
    if (mOpen && ms)             ic = 32'h8000_0000;
    else if (mOpen && ho)        ic = 32'h8000_0002;
    else if (sOpen && ss)        ic = 32'h8000_0000;
    else if (sOpen && tm && st)  ic = 32'h8000_0001;
    else begin hit = 1'b0; ic = 32'h0; end
    eValid = 1'b0;
    if (hit || tr) begin
      eRedir = 32'(mP) * 32'd64;
      eEpc = pc; eCause = hit ? ic : tc; eValid = 1'b1;
      p2 = p1; i2 = i1; p1 = mP; i1 = mI; mP = 2'd3; mI = 1'b0; mv = 2'd3;
    end else if (rt) begin
      eRedir = eEpc; eValid = 1'b1;
      mP = p1; mI = i1; p1 = p2; i1 = i2; p2 = 2'd0; i2 = 1'b1;
    end else if (we) begin
      if (wd[1:0] != 2'd2)   mP = wd[1:0];
      if (wd[4:3] != 2'd2)   p1 = wd[4:3];
      if (wd[7:6] != 2'd2)   p2 = wd[7:6];
      if (wd[10:9] != 2'd2)  mv = wd[10:9];
      mI = wd[2]; i1 = wd[5]; i2 = wd[8]; st = wd[11];
    end
    @(posedge clk); #1;
    checkAll(req);
    trapReq = 0; retReq = 0; msip = 0; ssip = 0; hostPending = 0; timerPending = 0; csrWe = 0;
  endtask

  task automatic wr(input string req, input logic [11:0] wd);
    apply(req, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, wd);
  endtask

  initial begin
    #(20ns * 200000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    mP = 2'd3; mI = 0; p1 = 2'd1; i1 = 0; p2 = 2'd1; i2 = 0; mv = 2'd0; st = 0;
    eEpc = 0; eCause = 0; eRedir = 32'h100; eValid = 0;
    #35 rstN = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    chk("R1 status", 32'(statusOut), 32'h04B);
    chk("R1 redirPc", redirPc, 32'h100);
    checkAll("R1");

    // R7 R10: every write value
    for (int w = 0; w < 4096; w++) wr("R7 R10 write sweep", 12'(w));

    // R5 R6 R8 R9: interrupt sweep
    for (int pv = 0; pv < 4; pv++) begin
      if (pv == 2) continue;
      for (int e = 0; e < 2; e++)
        for (int t = 0; t < 2; t++)
          for (int src = 0; src < 16; src++) begin
            wr("R10 setup", {t[0], 2'd0, 1'b1, 2'd3, 1'b0, 2'd1, e[0], pv[1:0]});
            apply("R5 R6 R8 R9 irq sweep", 32'h4000 + 32'(src), 1'b0, 32'h0, 1'b0,
                  src[0], src[1], src[2], src[3], 1'b0, 12'h0);
          end
    end

    // R2 R4: fault from user
    wr("R2 setup", {1'b0, 2'd0, 1'b1, 2'd3, 1'b0, 2'd1, 1'b1, 2'd0});
    apply("R2 R4 fault from user", 32'h1234, 1'b1, 32'd5, 1'b0, 0, 0, 0, 0, 1'b0, 12'h0);
    // R4: nested fault from machine, vector 0xC0
    apply("R4 nested fault", 32'h2000, 1'b1, 32'd7, 1'b0, 0, 0, 0, 0, 1'b0, 12'h0);
    // R3: two returns then a third refill
    apply("R3 return 1", 32'h0, 1'b0, 32'h0, 1'b1, 0, 0, 0, 0, 1'b0, 12'h0);
    apply("R3 return 2", 32'h0, 1'b0, 32'h0, 1'b1, 0, 0, 0, 0, 1'b0, 12'h0);
    apply("R3 return 3", 32'h0, 1'b0, 32'h0, 1'b1, 0, 0, 0, 0, 1'b0, 12'h0);
    // R9: fault with return and write in the same cycle
    apply("R9 fault over return/write", 32'h3000, 1'b1, 32'd2, 1'b1, 0, 0, 0, 0, 1'b1, 12'hFFF);
    // R9: return drops a simultaneous write
    apply("R9 return over write", 32'h0, 1'b0, 32'h0, 1'b1, 0, 0, 0, 0, 1'b1, 12'h000);
    // R9: interrupt over fault
    wr("R9 setup", {1'b1, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd1});
    apply("R9 timer over fault", 32'h5000, 1'b1, 32'd3, 1'b0, 0, 0, 0, 1, 1'b0, 12'h0);
    // idle cycle: redirect drops
    apply("R4 idle", 32'h0, 1'b0, 32'h0, 1'b0, 0, 0, 0, 0, 1'b0, 12'h0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule